// File: doc/BRIEF.md
# Comparator Event Timer Channel

This block is a single channel of a multi-channel event timer. A shared main counter, which runs freely outside the block, is compared every cycle against the channel's own comparator register. When the count reaches the comparator, the channel emits a one-clock fire strobe. A separate interrupt router consumes that strobe. The channel holds a visible comparator, a hidden period register, a wrap flag and four configuration bits. Software reaches these through three write strobes that share one half-width data word: one strobe for the configuration word, one for the low comparator half and one for the high comparator half.

In one-shot mode the channel fires once and then goes idle. In periodic mode each match adds the period to the comparator. If the count has already run past several periods, the comparator keeps advancing, one period per cycle, until it is ahead of the count again. During that catch-up the channel fires only once. In 32-bit mode only the low halves are compared, and a one-shot channel also produces an early event when the counter's low half wraps before the match. The set-value bit lets software load the comparator of a periodic channel directly, for one write.

Top module: `ect_channel`

## Requirements
- R1: After reset the comparator holds all ones, the period is zero, the wrap flag is clear, and both fire_o and clr_req_o are low.
- R2: A one-shot channel fires when the signed difference comparator minus count is zero or negative. The 64-bit difference is used when 32-bit mode is off. fire_o is high for exactly one clock, and the channel stays silent afterwards until it is re-armed.
- R3: In periodic mode with a nonzero period, each cycle in which the count has reached the comparator adds the period to the comparator. Only the first of a run of such cycles produces a fire pulse.
- R4: With 32-bit mode on, the comparison uses the signed difference of the low halves and ignores the upper halves. Writing a configuration word with the 32-bit bit set clears the upper halves of both the comparator and the period.
- R5: When a 32-bit one-shot channel is armed and the low half of the counter will wrap before it reaches the comparator, the channel fires once when the wrap is seen (the low count is lower than in the previous cycle). It then fires again at the real match.
- R6: The configuration word is wdata_i[0] enable, wdata_i[1] periodic, wdata_i[2] 32-bit mode and wdata_i[3] set-value. A comparator-half write changes the comparator only when the channel is one-shot or set-value is 1. A low-half write in periodic mode also loads the low half of the period. A high-half write in periodic mode with set-value at 0 loads the high half of the period. Any comparator-half write clears set-value.
- R7: Any value loaded into the period has its top bit forced to zero. In 32-bit mode that is bit 31, otherwise it is bit 63.
- R8: No fire pulse occurs while glb_en_i is low. A rising glb_en_i re-arms an enabled channel.
- R9: A rising channel enable arms the comparison; the first compare takes place three cycles after the write. A falling channel enable cancels any pending event and raises clr_req_o for one clock, one cycle after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| count_i | input | CNT_W | Shared main counter value |
| glb_en_i | input | 1 | Global enable for counting and events |
| cfg_wr_i | input | 1 | Write strobe for the configuration word |
| cmp_lo_wr_i | input | 1 | Write strobe for the low comparator half |
| cmp_hi_wr_i | input | 1 | Write strobe for the high comparator half |
| wdata_i | input | CNT_W/2 | Write data shared by the three strobes |
| fire_o | output | 1 | One-clock event strobe to the interrupt router |
| clr_req_o | output | 1 | One-clock request to clear this channel's interrupt |

## Verification
Two situations are the hardest to reach from the ports: the periodic catch-up run and the 32-bit wrap event. In the catch-up run the count has overtaken the comparator by more than one period. In the wrap case the channel must be armed with the low count just below the wrap point and a comparator just past it. The bench drives the main counter directly, so it can jump the count forward by several periods, or place it at 0xFFFFFFF0 before enabling and then step it across the wrap. A stimulus table walks the periodic sequence one cycle per row, including the repeated rows in which the comparator silently advances. Directed sequences cover the wrap, the truncation, the period mask and the enable gating.

// File: rtl/ect_pkg.sv
// Package ect_pkg
// Shared configuration layout for the comparator event timer channel.
// Assumes the configuration word sits in the low bits of the write data.
package ect_pkg;

    localparam int CFG_W          = 4;
    localparam int CFG_EN_BIT     = 0;
    localparam int CFG_PER_BIT    = 1;
    localparam int CFG_WIDE32_BIT = 2;
    localparam int CFG_SETV_BIT   = 3;

    // Packed so that the last field lands on bit 0 of the write word.
    typedef struct packed {
        logic setval;
        logic wide32;
        logic periodic;
        logic enable;
    } cfg_t;

endpackage

// File: rtl/ect_regs.sv
// Module ect_regs
// Holds the configuration bits, the visible comparator and the hidden
// period. Applies the write rules, the set-value handshake, the period
// top-bit mask and the truncation to 32 bits. Periodic advance comes in
// from the controller on adv_i.
// Assumes at most one write strobe per cycle; if several occur, a later
// one in source order wins.
module ect_regs
    import ect_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr_i,
    input  logic               cmp_lo_wr_i,
    input  logic               cmp_hi_wr_i,
    input  logic [CNT_W/2-1:0] wdata_i,
    input  logic               adv_i,
    output cfg_t               cfg_o,
    output logic [CNT_W-1:0]   cmp_o,
    output logic [CNT_W-1:0]   period_o
);

    localparam int HW = CNT_W / 2;

    cfg_t             cfg_q;
    logic [CNT_W-1:0] cmp_q;
    logic [CNT_W-1:0] per_q;
    logic [CNT_W-1:0] sum;
    logic [HW-1:0]    per_lo_val;
    logic [HW-1:0]    per_hi_val;
    logic             cmp_writable;

    // Next comparator after one periodic step, wrapped to 32 bits when needed.
    always_comb begin
        sum = cmp_q + per_q;
        if (cfg_q.wide32) begin
            sum[CNT_W-1:HW] = '0;
        end
    end

    // Period values after the top-bit mask, and the set-value gate.
    always_comb begin
        per_lo_val   = cfg_q.wide32 ? {1'b0, wdata_i[HW-2:0]} : wdata_i;
        per_hi_val   = cfg_q.wide32 ? '0 : {1'b0, wdata_i[HW-2:0]};
        cmp_writable = !cfg_q.periodic || cfg_q.setval;
    end

    // Register update: reset, advance, configuration and comparator writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
            cmp_q <= '1;
            per_q <= '0;
        end else begin
            if (adv_i) begin
                cmp_q <= sum;
            end
            if (cfg_wr_i) begin
                cfg_q <= cfg_t'(wdata_i[CFG_W-1:0]);
                if (wdata_i[CFG_WIDE32_BIT]) begin
                    cmp_q[CNT_W-1:HW] <= '0;
                    per_q[CNT_W-1:HW] <= '0;
                end
            end
            if (cmp_lo_wr_i) begin
                if (cmp_writable) begin
                    cmp_q[HW-1:0] <= wdata_i;
                end
                if (cfg_q.periodic) begin
                    per_q[HW-1:0] <= per_lo_val;
                end
                cfg_q.setval <= 1'b0;
            end
            if (cmp_hi_wr_i) begin
                if (cmp_writable) begin
                    if (!cfg_q.wide32) begin
                        cmp_q[CNT_W-1:HW] <= wdata_i;
                    end
                end else begin
                    per_q[CNT_W-1:HW] <= per_hi_val;
                end
                cfg_q.setval <= 1'b0;
            end
        end
    end

    assign cfg_o    = cfg_q;
    assign cmp_o    = cmp_q;
    assign period_o = per_q;

endmodule

// File: rtl/ect_ctrl.sv
// Module ect_ctrl
// Arms and evaluates the channel. It computes the reached test in 32-bit
// or 64-bit signed form, decides the one-shot, periodic and wrap events,
// drives the periodic advance and registers the fire and clear strobes.
// Assumes count_i is the shared main counter, sampled once per clock.
module ect_ctrl #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count_i,
    input  logic             glb_en_i,
    input  logic             en_i,
    input  logic             periodic_i,
    input  logic             wide32_i,
    input  logic [CNT_W-1:0] cmp_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic             cmp_wr_i,
    output logic             adv_o,
    output logic             fire_o,
    output logic             clr_req_o
);

    localparam int HW = CNT_W / 2;

    logic          act, act_q, en_q;
    logic          arm_q, armed_q, wrap_q, catch_q;
    logic          fire_q, clr_q;
    logic [HW-1:0] prev_lo_q;
    logic [HW-1:0] d32, dist32;
    logic [CNT_W-1:0] d64;
    logic          reached, wrapped, wrap_set, per_mode, evaluating;

    // Compare, wrap-distance and mode decode for the current cycle.
    always_comb begin
        act        = en_i && glb_en_i;
        d32        = cmp_i[HW-1:0] - count_i[HW-1:0];
        d64        = cmp_i - count_i;
        reached    = wide32_i ? ((d32 == '0) || d32[HW-1])
                              : ((d64 == '0) || d64[CNT_W-1]);
        dist32     = reached ? {{(HW-1){1'b0}}, 1'b1} : d32;
        wrap_set   = wide32_i && !periodic_i && (~count_i[HW-1:0] < dist32);
        wrapped    = count_i[HW-1:0] < prev_lo_q;
        per_mode   = periodic_i && (period_i != '0);
        evaluating = act && !arm_q && armed_q;
        adv_o      = evaluating && per_mode && reached;
    end

    // Arm, evaluate and strobe sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q     <= 1'b0;
            en_q      <= 1'b0;
            arm_q     <= 1'b0;
            armed_q   <= 1'b0;
            wrap_q    <= 1'b0;
            catch_q   <= 1'b0;
            fire_q    <= 1'b0;
            clr_q     <= 1'b0;
            prev_lo_q <= '0;
        end else begin
            act_q     <= act;
            en_q      <= en_i;
            prev_lo_q <= count_i[HW-1:0];
            fire_q    <= 1'b0;
            clr_q     <= en_q && !en_i;
            arm_q     <= act && (!act_q || cmp_wr_i);
            if (!act) begin
                armed_q <= 1'b0;
                wrap_q  <= 1'b0;
                catch_q <= 1'b0;
            end else if (arm_q) begin
                armed_q <= 1'b1;
                wrap_q  <= wrap_set;
                catch_q <= 1'b0;
            end else if (armed_q) begin
                if (per_mode) begin
                    if (reached) begin
                        fire_q  <= !catch_q;
                        catch_q <= 1'b1;
                    end else begin
                        catch_q <= 1'b0;
                    end
                end else if (wrap_q) begin
                    if (wrapped) begin
                        fire_q <= 1'b1;
                        wrap_q <= 1'b0;
                        if (reached) begin
                            armed_q <= 1'b0;
                        end
                    end
                end else if (reached) begin
                    fire_q  <= 1'b1;
                    armed_q <= 1'b0;
                end
            end
        end
    end

    assign fire_o    = fire_q;
    assign clr_req_o = clr_q;

endmodule

// File: rtl/ect_channel.sv
// Module ect_channel
// Top of one comparator event timer channel: register storage plus
// arm/evaluate control. fire_o goes to an external interrupt router.
// Assumes a synchronous active-low reset and a shared free-running counter.
module ect_channel
    import ect_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CNT_W-1:0]   count_i,
    input  logic               glb_en_i,
    input  logic               cfg_wr_i,
    input  logic               cmp_lo_wr_i,
    input  logic               cmp_hi_wr_i,
    input  logic [CNT_W/2-1:0] wdata_i,
    output logic               fire_o,
    output logic               clr_req_o
);

    cfg_t             cfg_q;
    logic [CNT_W-1:0] cmp_q;
    logic [CNT_W-1:0] period_q;
    logic             adv;

    // Storage for configuration, comparator and period.
    ect_regs #(.CNT_W(CNT_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr_i    (cfg_wr_i),
        .cmp_lo_wr_i (cmp_lo_wr_i),
        .cmp_hi_wr_i (cmp_hi_wr_i),
        .wdata_i     (wdata_i),
        .adv_i       (adv),
        .cfg_o       (cfg_q),
        .cmp_o       (cmp_q),
        .period_o    (period_q)
    );

    // Event decision and output strobes.
    ect_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .count_i    (count_i),
        .glb_en_i   (glb_en_i),
        .en_i       (cfg_q.enable),
        .periodic_i (cfg_q.periodic),
        .wide32_i   (cfg_q.wide32),
        .cmp_i      (cmp_q),
        .period_i   (period_q),
        .cmp_wr_i   (cmp_lo_wr_i || cmp_hi_wr_i),
        .adv_o      (adv),
        .fire_o     (fire_o),
        .clr_req_o  (clr_req_o)
    );

endmodule

// File: rtl/ect_channel_checker.sv
// Module ect_channel_checker
// Concurrent checks on the channel's ports and stored state; bound into
// every ect_channel instance.
module ect_channel_checker
    import ect_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             glb_en_i,
    input logic             cmp_lo_wr_i,
    input logic             cmp_hi_wr_i,
    input logic             fire_o,
    input logic             clr_req_o,
    input cfg_t             cfg,
    input logic [CNT_W-1:0] cmp,
    input logic [CNT_W-1:0] period
);

    localparam int HW = CNT_W / 2;

    a_r1_reset_values: assert property (@(posedge clk)
        !rst_n |=> (cmp == '1 && period == '0 && !fire_o && !clr_req_o));

    a_r4_trunc_upper: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.wide32 |-> (cmp[CNT_W-1:HW] == '0 && period[CNT_W-1:HW] == '0));

    a_r6_setval_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_lo_wr_i || cmp_hi_wr_i) |=> !cfg.setval);

    a_r7_period_msb: assert property (@(posedge clk) disable iff (!rst_n)
        !period[CNT_W-1]);

    a_r8_global_gate: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |-> $past(glb_en_i));

    a_r9_disable_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cfg.enable) |=> (clr_req_o && !fire_o));

endmodule

bind ect_channel ect_channel_checker #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .glb_en_i    (glb_en_i),
    .cmp_lo_wr_i (cmp_lo_wr_i),
    .cmp_hi_wr_i (cmp_hi_wr_i),
    .fire_o      (fire_o),
    .clr_req_o   (clr_req_o),
    .cfg         (cfg_q),
    .cmp         (cmp_q),
    .period      (period_q)
);

// File: tb/ect_channel_test.sv
// Bench for ect_channel: a periodic vector table walked once per cycle,
// then directed sequences for reset, wrap, truncation and gating.
module ect_channel_test;

    localparam int CNT_W = 64;
    localparam int HW    = CNT_W / 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [CNT_W-1:0] count = '0;
    logic             glb_en = 1'b1;
    logic             cfg_wr = 1'b0;
    logic             lo_wr = 1'b0;
    logic             hi_wr = 1'b0;
    logic [HW-1:0]    wdata = '0;
    logic             fire;
    logic             clr_req;

    int checks = 0;
    int errors = 0;

    // Periodic table: {expected fire, count}; cmp starts at 20, period 10.
    localparam int NVEC = 13;
    localparam logic [CNT_W:0] VEC [NVEC] = '{
        {1'b0, 64'd5},  {1'b0, 64'd15}, {1'b1, 64'd20}, {1'b0, 64'd21},
        {1'b0, 64'd29}, {1'b1, 64'd30}, {1'b0, 64'd31}, {1'b1, 64'd55},
        {1'b0, 64'd55}, {1'b0, 64'd55}, {1'b0, 64'd59}, {1'b1, 64'd60},
        {1'b0, 64'd61}
    };

    ect_channel #(.CNT_W(CNT_W)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .count_i     (count),
        .glb_en_i    (glb_en),
        .cfg_wr_i    (cfg_wr),
        .cmp_lo_wr_i (lo_wr),
        .cmp_hi_wr_i (hi_wr),
        .wdata_i     (wdata),
        .fire_o      (fire),
        .clr_req_o   (clr_req)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // sel: 0 config, 1 low half, 2 high half.
    task automatic wr(input int sel, input logic [HW-1:0] d);
        @(negedge clk);
        wdata  = d;
        cfg_wr = (sel == 0);
        lo_wr  = (sel == 1);
        hi_wr  = (sel == 2);
        @(negedge clk);
        cfg_wr = 1'b0;
        lo_wr  = 1'b0;
        hi_wr  = 1'b0;
    endtask

    task automatic fires(input int n, output int f);
        f = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            f += int'(fire);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n  = 1'b0;
        count  = '0;
        glb_en = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int f;
        // R1: reset state of the outputs.
        do_reset();
        chk("R1 fire after reset", fire, 0);
        chk("R1 clr after reset", clr_req, 0);

        // R1/R2: comparator resets to all ones; one-shot fires once.
        count = 64'hFFFF_FFFF_FFFF_FFF0;
        wr(0, 32'h1);
        fires(5, f);
        chk("R1 no fire before all-ones", f, 0);
        count = '1;
        fires(6, f);
        chk("R2 single one-shot fire", f, 1);
        wr(0, 32'h0);
        @(negedge clk);
        chk("R9 clear request pulse", clr_req, 1);
        @(negedge clk);
        chk("R9 clear request one cycle", clr_req, 0);

        // R3/R6: periodic table with the set-value handshake.
        do_reset();
        wr(0, 32'hA);
        wr(2, 32'h0);
        wr(0, 32'hA);
        wr(1, 32'd20);
        wr(1, 32'd10);
        wr(0, 32'h3);
        repeat (4) @(negedge clk);
        for (int i = 0; i < NVEC; i++) begin
            count = VEC[i][CNT_W-1:0];
            @(negedge clk);
            chk($sformatf("R3 R6 periodic vector %0d", i), fire, VEC[i][CNT_W]);
        end

        // R8: global enable gates events, rise re-arms.
        do_reset();
        glb_en = 1'b0;
        wr(2, 32'h0);
        wr(1, 32'd50);
        count = 64'd60;
        wr(0, 32'h1);
        fires(6, f);
        chk("R8 no fire while global low", f, 0);
        glb_en = 1'b1;
        fires(6, f);
        chk("R8 fire after global rise", f, 1);

        // R5/R4: 32-bit one-shot wrap event then the real match.
        do_reset();
        wr(0, 32'h4);
        wr(1, 32'h10);
        count = 64'h0000_0000_FFFF_FFF0;
        wr(0, 32'h5);
        fires(5, f);
        chk("R5 no fire before wrap", f, 0);
        count = 64'h0000_0001_0000_0002;
        fires(3, f);
        chk("R5 wrap event", f, 1);
        count = 64'h0000_0001_0000_0005;
        fires(3, f);
        chk("R5 no fire between wrap and match", f, 0);
        count = 64'h0000_0001_0000_0010;
        fires(3, f);
        chk("R4 R5 low-half match fires", f, 1);

        // R4: entering 32-bit mode truncates the comparator permanently.
        do_reset();
        wr(2, 32'h1);
        wr(1, 32'h20);
        wr(0, 32'h4);
        wr(0, 32'h1);
        fires(5, f);
        chk("R4 no early fire", f, 0);
        count = 64'h20;
        fires(3, f);
        chk("R4 truncated comparator matches", f, 1);

        // R7: period top bit forced to zero in 32-bit mode.
        do_reset();
        wr(0, 32'hE);
        wr(1, 32'd10);
        wr(1, 32'h8000_0005);
        wr(0, 32'h7);
        repeat (4) @(negedge clk);
        count = 64'd10;
        @(negedge clk);
        chk("R7 first periodic fire", fire, 1);
        count = 64'd11;
        @(negedge clk);
        chk("R7 no fire between", fire, 0);
        count = 64'd15;
        @(negedge clk);
        chk("R7 masked period fire", fire, 1);

        // R9: disabling cancels a pending event.
        do_reset();
        wr(2, 32'h0);
        wr(1, 32'd100);
        wr(0, 32'h1);
        repeat (4) @(negedge clk);
        wr(0, 32'h0);
        @(negedge clk);
        chk("R9 clear request on disable", clr_req, 1);
        count = 64'd100;
        fires(5, f);
        chk("R9 cancelled event stays silent", f, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule